// File: doc/BRIEF.md
# DC-Balanced Three-Lane Frame Decoder

This block sits behind the bit-sampling front end of a three-lane serial link whose transmitter keeps each lane DC-balanced by optionally inverting every 7-bit group. Each lane delivers nine bits per parallel period. The first two bits are a complementary pair that says whether the seven data bits that follow were inverted. The block recovers the frames, checks each pair, restores the original polarity and merges the three 7-bit groups into one 21-bit parallel word.

The whole design runs on one fast clock. A bit-enable input marks the cycles that carry a sampled bit on all three lanes, so the serial bit time is one ninth of the parallel period. A frame marker taken from the clock lane identifies the first bit of a frame. Each finished word comes with a one-cycle valid pulse and a per-lane pair-error flag. A parallel strobe output follows the word. A configuration input chooses whether the downstream logic should latch the word on the strobe's rising edge or on its falling edge.

Top module: `dcb_deser`

## Requirements
- R1: A bit is taken from every lane only in cycles where `bit_en` is 1. In cycles where `bit_en` is 0, `lane_in` and `frame_mark` have no effect. Inside a frame the first bit is the flag A, the second is the flag B, and then come data bits 6, 5, 4, 3, 2, 1 and 0 of that lane's group.
- R2: Lane 0 fills `out_word[6:0]`, lane 1 fills `out_word[13:7]` and lane 2 fills `out_word[20:14]`.
- R3: A pair A=1, B=0 means the group was sent inverted, and the block outputs the complement of the received bits. A pair A=0, B=1 means the group was sent as is, and the block outputs it unchanged.
- R4: A pair with A equal to B sets that lane's bit of `code_err` and passes the received data through without inversion. A valid pair clears the bit. The flag changes only together with the word.
- R5: `out_word`, `code_err` and `word_valid` all update on the clock edge that samples the ninth bit of a frame. `word_valid` is high for exactly that one following cycle.
- R6: Between valid pulses, `out_word` and `code_err` hold their values.
- R7: A bit sampled while `frame_mark` is 1 is flag A of a new frame, and any partly received frame is dropped. Before the first marker no word is produced. After a complete frame, the next nine sampled bits form the next frame even without a marker.
- R8: In the cycle after a valid pulse, `strobe_out` is 1 when `strobe_falling` was 0 at that edge, and 0 when it was 1. In every other cycle out of reset, `strobe_out` holds the opposite level. The selected edge therefore comes one cycle after the word changes.
- R9: Reset is synchronous and active low. While reset is asserted, `out_word` is 0, `code_err` is 0, `word_valid` is 0 and `strobe_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Marks a cycle carrying one sampled bit per lane |
| frame_mark | input | 1 | The sampled bit is the first bit of a frame |
| lane_in | input | 3 | Sampled serial bit of each lane |
| strobe_falling | input | 1 | 0: data valid at the strobe's rising edge, 1: at its falling edge |
| out_word | output | 21 | Decoded parallel word |
| word_valid | output | 1 | One-cycle pulse when a new word is presented |
| code_err | output | 3 | Per-lane flag for an equal control pair |
| strobe_out | output | 1 | Parallel output strobe |

## Verification
If the frame position counter slips, every following word comes out shifted by some bits. The word valid pulses also drift away from the ninth enabled bit. Both show up at the first frame after the fault.

A fault in the pair decoding shows at the same valid pulse. It appears as inverted groups or as a wrong `code_err` bit.

A wrong strobe level shows one cycle later. The reference model checks every port on every clock, so even a one-cycle deviation is reported.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
   localparam int CTRL_W = 2;

   typedef enum logic [1:0] {
      PAIR_LOW    = 2'b00,
      PAIR_PLAIN  = 2'b01,
      PAIR_INVERT = 2'b10,
      PAIR_HIGH   = 2'b11
   } pair_code_e;
endpackage

// File: rtl/dcb_frame_ctrl.sv
module dcb_frame_ctrl #(
   parameter int FRAME_W = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic frame_mark,
   output logic frame_done
);
   localparam int PW = $clog2(FRAME_W);
   localparam logic [PW-1:0] LAST = PW'(FRAME_W - 1);

   logic [PW-1:0] pos_q;
   logic          aligned_q;

   initial assert (FRAME_W >= 3) else $error("frame must hold a pair and data");

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q     <= '0;
         aligned_q <= 1'b0;
      end else if (bit_en) begin
         if (frame_mark) begin
            aligned_q <= 1'b1;
            pos_q     <= PW'(1);
         end else if (aligned_q) begin
            pos_q <= (pos_q == LAST) ? '0 : pos_q + PW'(1);
         end
      end
   end

   assign frame_done = bit_en && !frame_mark && aligned_q && (pos_q == LAST);

   AST_MARK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && frame_mark) |=> !frame_done); // R7
endmodule

// File: rtl/dcb_pair_decode.sv
module dcb_pair_decode
   import dcb_pkg::*;
#(
   parameter int DATA_W = 7
) (
   input  logic [CTRL_W-1:0] pair,
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] data,
   output logic              bad
);
   always_comb begin
      data = raw;
      bad  = 1'b0;
      case (pair_code_e'(pair))
         PAIR_INVERT: data = ~raw;
         PAIR_PLAIN:  data = raw;
         default:     bad  = 1'b1;
      endcase
   end
endmodule

// File: rtl/dcb_lane_rx.sv
module dcb_lane_rx
   import dcb_pkg::*;
#(
   parameter int DATA_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              serial_in,
   input  logic              frame_done,
   output logic [DATA_W-1:0] group_q,
   output logic              err_q
);
   localparam int FRAME_W = DATA_W + CTRL_W;

   logic [FRAME_W-2:0] sr_q;
   logic [FRAME_W-1:0] full;
   logic [DATA_W-1:0]  dec_data;
   logic               dec_bad;

   assign full = {sr_q, serial_in};

   always_ff @(posedge clk) begin
      if (!rst_n) sr_q <= '0;
      else if (shift_en) sr_q <= full[FRAME_W-2:0];
   end

   dcb_pair_decode #(.DATA_W(DATA_W)) u_dec (
      .pair (full[FRAME_W-1 -: CTRL_W]),
      .raw  (full[DATA_W-1:0]),
      .data (dec_data),
      .bad  (dec_bad)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         group_q <= '0;
         err_q   <= 1'b0;
      end else if (frame_done) begin
         group_q <= dec_data;
         err_q   <= dec_bad;
      end
   end

   AST_GROUP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |=> $stable(group_q)); // R6
   AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |=> $stable(err_q)); // R4
endmodule

// File: rtl/dcb_strobe_gen.sv
module dcb_strobe_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic word_valid,
   input  logic strobe_falling,
   output logic strobe_out
);
   always_ff @(posedge clk) begin
      if (!rst_n) strobe_out <= 1'b0;
      else        strobe_out <= word_valid ? !strobe_falling : strobe_falling;
   end

   AST_STROBE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(word_valid) |-> (strobe_out != $past(strobe_falling))); // R8
endmodule

// File: rtl/dcb_deser.sv
module dcb_deser
   import dcb_pkg::*;
#(
   parameter int LANES  = 3,
   parameter int DATA_W = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bit_en,
   input  logic                    frame_mark,
   input  logic [LANES-1:0]        lane_in,
   input  logic                    strobe_falling,
   output logic [LANES*DATA_W-1:0] out_word,
   output logic                    word_valid,
   output logic [LANES-1:0]        code_err,
   output logic                    strobe_out
);
   localparam int FRAME_W = DATA_W + CTRL_W;

   logic frame_done;

   initial assert (LANES >= 1) else $error("need at least one lane");
   initial assert (DATA_W >= 1) else $error("need at least one data bit");

   dcb_frame_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .frame_mark (frame_mark),
      .frame_done (frame_done)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [DATA_W-1:0] grp;
      logic              err;

      dcb_lane_rx #(.DATA_W(DATA_W)) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .shift_en   (bit_en),
         .serial_in  (lane_in[l]),
         .frame_done (frame_done),
         .group_q    (grp),
         .err_q      (err)
      );

      assign out_word[l*DATA_W +: DATA_W] = grp;
      assign code_err[l]                  = err;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) word_valid <= 1'b0;
      else        word_valid <= frame_done;
   end

   dcb_strobe_gen u_strobe (
      .clk            (clk),
      .rst_n          (rst_n),
      .word_valid     (word_valid),
      .strobe_falling (strobe_falling),
      .strobe_out     (strobe_out)
   );

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid); // R5
   AST_VALID_FROM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> $past(bit_en)); // R1
endmodule

// File: tb/dcb_deser_tb.sv
module dcb_deser_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic        frame_mark = 1'b0;
   logic [2:0]  lane_in = 3'b000;
   logic        strobe_falling = 1'b0;
   logic [20:0] out_word;
   logic        word_valid;
   logic [2:0]  code_err;
   logic        strobe_out;

   int    checks = 0;
   int    failures = 0;
   string scen = "R9 reset";
   bit    started = 0;

   always #2 clk = ~clk;

   dcb_deser u_dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_mark(frame_mark),
      .lane_in(lane_in), .strobe_falling(strobe_falling), .out_word(out_word),
      .word_valid(word_valid), .code_err(code_err), .strobe_out(strobe_out)
   );

   // behavioural reference model
   bit        lq [3][$];
   bit        aligned = 0;
   bit [20:0] m_word = '0;
   bit [2:0]  m_err = '0;
   bit        m_valid = 0;
   bit        m_strobe = 0;

   always @(posedge clk) begin
      started <= 1;
      if (!rst_n) begin
         m_word = '0; m_err = '0; m_valid = 0; m_strobe = 0; aligned = 0;
         for (int l = 0; l < 3; l++) lq[l].delete();
      end else begin
         m_strobe = m_valid ? !strobe_falling : strobe_falling;
         m_valid = 0;
         if (bit_en) begin
            if (frame_mark) begin
               aligned = 1;
               for (int l = 0; l < 3; l++) lq[l].delete();
            end
            if (aligned) begin
               for (int l = 0; l < 3; l++) lq[l].push_back(lane_in[l]);
               if (lq[0].size() == 9) begin
                  for (int l = 0; l < 3; l++) begin
                     bit [6:0] g;
                     for (int k = 0; k < 7; k++) g[6-k] = lq[l][2+k];
                     if (lq[l][0] == 1 && lq[l][1] == 0) g = ~g;
                     m_err[l] = (lq[l][0] == lq[l][1]);
                     m_word[7*l +: 7] = g;
                     lq[l].delete();
                  end
                  m_valid = 1;
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (started) begin
         checks += 4;
         if (out_word !== m_word) begin
            failures++;
            $display("FAIL %s R1 R2 R3 R6 word: actual=%h expected=%h", scen, out_word, m_word);
         end
         if (word_valid !== m_valid) begin
            failures++;
            $display("FAIL %s R5 valid: actual=%b expected=%b", scen, word_valid, m_valid);
         end
         if (code_err !== m_err) begin
            failures++;
            $display("FAIL %s R4 code_err: actual=%b expected=%b", scen, code_err, m_err);
         end
         if (strobe_out !== m_strobe) begin
            failures++;
            $display("FAIL %s R8 strobe: actual=%b expected=%b", scen, strobe_out, m_strobe);
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_en = 0; frame_mark = 1'($urandom); lane_in = 3'($urandom);
      end
   endtask

   task automatic send_frame(input logic [20:0] data, input logic [2:0] inv,
                             input logic [2:0] bad, input logic badv,
                             input logic mark, input int gap, input int nbits);
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk);
         bit_en = 1;
         frame_mark = mark && (i == 0);
         for (int l = 0; l < 3; l++) begin
            logic [6:0] g;
            g = data[7*l +: 7];
            if (bad[l])      lane_in[l] = (i < 2) ? badv : g[8-i];
            else if (inv[l]) lane_in[l] = (i == 0) ? 1'b1 : (i == 1) ? 1'b0 : ~g[8-i];
            else             lane_in[l] = (i == 0) ? 1'b0 : (i == 1) ? 1'b1 : g[8-i];
         end
         if (gap > 0) idle(gap);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      scen = "R7 no-marker";
      send_frame(21'h1ABCDE, 3'b000, 3'b000, 0, 0, 0, 9);
      send_frame(21'h0F0F0F, 3'b000, 3'b000, 0, 0, 0, 5);
      idle(3);
      scen = "R2 plain";
      send_frame(21'h1FC07F, 3'b000, 3'b000, 0, 1, 0, 9);
      send_frame(21'h000001, 3'b000, 3'b000, 0, 1, 0, 9);
      idle(2);
      send_frame(21'h100080, 3'b000, 3'b000, 0, 1, 0, 9);
      scen = "R3 invert";
      send_frame(21'h12345A, 3'b111, 3'b000, 0, 1, 0, 9);
      send_frame(21'h0ACE35, 3'b010, 3'b000, 0, 1, 0, 9);
      send_frame(21'h1F00AA, 3'b101, 3'b000, 0, 1, 1, 9);
      scen = "R4 badpair";
      send_frame(21'h055555, 3'b000, 3'b001, 1, 1, 0, 9);
      send_frame(21'h0AAAAA, 3'b100, 3'b010, 0, 1, 0, 9);
      send_frame(21'h1C3C3C, 3'b001, 3'b110, 1, 1, 0, 9);
      idle(4);
      send_frame(21'h0357AC, 3'b000, 3'b000, 0, 1, 0, 9);
      scen = "R7 continue";
      send_frame(21'h17E2B4, 3'b011, 3'b000, 0, 1, 0, 9);
      send_frame(21'h0C1D2E, 3'b100, 3'b000, 0, 0, 0, 9);
      send_frame(21'h1111FF, 3'b000, 3'b000, 0, 0, 0, 9);
      scen = "R7 early-mark";
      send_frame(21'h1FFFFF, 3'b000, 3'b000, 0, 1, 0, 4);
      send_frame(21'h0B7D31, 3'b001, 3'b000, 0, 1, 0, 9);
      send_frame(21'h1FFFFF, 3'b111, 3'b000, 0, 1, 0, 8);
      send_frame(21'h02468A, 3'b000, 3'b000, 0, 1, 0, 9);
      scen = "R1 gaps";
      send_frame(21'h13579B, 3'b010, 3'b000, 0, 1, 2, 9);
      send_frame(21'h0EDCBA, 3'b101, 3'b001, 0, 1, 1, 9);
      scen = "R8 falling";
      @(negedge clk); strobe_falling = 1;
      send_frame(21'h1A2B3C, 3'b000, 3'b000, 0, 1, 0, 9);
      send_frame(21'h04D5E6, 3'b110, 3'b000, 0, 1, 3, 9);
      idle(3);
      @(negedge clk); strobe_falling = 0;
      send_frame(21'h0F1E2D, 3'b001, 3'b000, 0, 1, 0, 9);
      idle(4);
      scen = "R9 reset";
      @(negedge clk); rst_n = 0;
      idle(3);
      @(negedge clk); rst_n = 1;
      send_frame(21'h155AA5, 3'b000, 3'b000, 0, 1, 0, 9);
      idle(4);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule